// File: doc/BRIEF.md
# Indexed Extension Registers with Cursor Position Latch

This block gives a host a two-register window onto a bank of 256 byte-wide extension registers. The host first writes an index byte to the select register, then reads or writes the data register. Each data access reaches the extension register that the index names. The index stays where it is after a data access, so the host must write it again to move to another register.

Four of the extension registers hold the cursor sprite position. Each coordinate takes two bytes, a low byte and a high byte. Writing the low bytes, or the horizontal high byte, only stores the value. Writing the vertical high byte copies all four bytes into the cursor position outputs on one clock edge, so the display never shows a half-updated position. A combinational comparator then reports whether the raster coordinate on the pixel inputs falls inside a fixed 12-by-22 cursor box anchored at the latched position.

Top module: `ext_cursor_regs`

## Requirements
- R1: After reset the index, all 256 extension registers and both latched cursor coordinates are zero. A read at the data offset therefore returns 0, and in_cursor_o is 1 for pixel (0,0).
- R2: A write at offset 0x0E stores wdata_i as the index. While reg_addr_i is 0x0E, rdata_o shows the index combinationally. The index changes only on a write to offset 0x0E.
- R3: A write at offset 0x0F stores wdata_i into the extension register selected by the index. While reg_addr_i is 0x0F, rdata_o shows that register combinationally. This holds for every index from 0x00 to 0xFF.
- R4: Writes at offset 0x0F to the horizontal-low (index 0x50), horizontal-high (0x51) or vertical-low (0x52) registers leave cursor_x_o and cursor_y_o unchanged.
- R5: A write at offset 0x0F with index 0x53 (vertical-high) updates both outputs at that clock edge. cursor_x_o becomes {reg[0x51], reg[0x50]} and cursor_y_o becomes {wdata_i, reg[0x52]}.
- R6: in_cursor_o requires cursor_x_o <= px_i < cursor_x_o + 12, with the sum computed without wrap-around.
- R7: in_cursor_o requires cursor_y_o <= py_i < cursor_y_o + 22, with the sum computed without wrap-around. in_cursor_o is 1 exactly when both R6 and R7 hold.
- R8: Any offset other than 0x0E and 0x0F reads as 0. A write at such an offset changes neither the index nor any extension register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 5 | Offset within the 32-byte register window |
| wr_i | input | 1 | Write strobe, sampled at the rising edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data for reg_addr_i |
| px_i | input | 16 | Raster pixel x coordinate |
| py_i | input | 16 | Raster pixel y coordinate |
| cursor_x_o | output | 16 | Latched cursor x position |
| cursor_y_o | output | 16 | Latched cursor y position |
| in_cursor_o | output | 1 | Current pixel lies inside the cursor box |

## Verification
Two functions can act in the same cycle. One is the commit write to the vertical-high register. The other is the comparator, which keeps judging the raster pixel against the latched box. The bench places the pixel inside the old box and outside the new one, or the reverse, and issues the commit write. It checks in_cursor_o just before the edge against the old position and just after the edge against the new one. Random sequences of write accesses, interleaved with position-register writes, also check that partial writes never move the box.

// File: rtl/ext_cursor_pkg.sv
package ext_cursor_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned POS_W  = 2 * DATA_W;
  localparam int unsigned OFFS_W = 5;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [POS_W-1:0]  pos_t;

  typedef struct packed {
    pos_t x;
    pos_t y;
  } cursor_pos_t;
endpackage

// File: rtl/ext_reg_file.sv
module ext_reg_file
  import ext_cursor_pkg::*;
#(
  parameter int unsigned NUM_REGS = 256,
  parameter logic [OFFS_W-1:0] OFFS_INDEX = 5'h0E,
  parameter logic [OFFS_W-1:0] OFFS_DATA  = 5'h0F,
  parameter int unsigned HLO_IDX = 8'h50,
  parameter int unsigned HHI_IDX = 8'h51,
  parameter int unsigned VLO_IDX = 8'h52,
  parameter int unsigned VHI_IDX = 8'h53,
  localparam int unsigned IDX_W = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OFFS_W-1:0] reg_addr_i,
  input  logic              wr_i,
  input  byte_t             wdata_i,
  output byte_t             rdata_o,
  output byte_t             hlo_o,
  output byte_t             hhi_o,
  output byte_t             vlo_o,
  output logic              commit_o
);
  logic [IDX_W-1:0] index_q;
  byte_t            mem_q [NUM_REGS];

  logic wr_index, wr_data;
  assign wr_index = wr_i && (reg_addr_i == OFFS_INDEX);
  assign wr_data  = wr_i && (reg_addr_i == OFFS_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q <= '0;
    end else if (wr_index) begin
      index_q <= wdata_i[IDX_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[g] <= '0;
      end else if (wr_data && (index_q == IDX_W'(g))) begin
        mem_q[g] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (reg_addr_i == OFFS_INDEX) begin
      rdata_o = DATA_W'(index_q);
    end else if (reg_addr_i == OFFS_DATA) begin
      rdata_o = mem_q[index_q];
    end
  end

  assign hlo_o    = mem_q[HLO_IDX];
  assign hhi_o    = mem_q[HHI_IDX];
  assign vlo_o    = mem_q[VLO_IDX];
  assign commit_o = wr_data && (index_q == IDX_W'(VHI_IDX));

  AST_INDEX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && reg_addr_i == OFFS_INDEX) |=> $stable(index_q)); // R2

  AST_DATA_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && reg_addr_i == OFFS_DATA) |=> (mem_q[$past(index_q)] == $past(wdata_i))); // R3

  AST_UNMAPPED_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i != OFFS_INDEX && reg_addr_i != OFFS_DATA) |-> (rdata_o == '0)); // R8
endmodule

// File: rtl/cursor_latch.sv
module cursor_latch
  import ext_cursor_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        commit_i,
  input  byte_t       hlo_i,
  input  byte_t       hhi_i,
  input  byte_t       vlo_i,
  input  byte_t       vhi_i,
  output cursor_pos_t pos_o
);
  cursor_pos_t pos_q;

  // all four bytes move on one edge; the high vertical byte is taken from the bus
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
    end else if (commit_i) begin
      pos_q.x <= {hhi_i, hlo_i};
      pos_q.y <= {vhi_i, vlo_i};
    end
  end

  assign pos_o = pos_q;

  AST_POS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(pos_q)); // R4

  AST_POS_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (pos_q.y[POS_W-1:DATA_W] == $past(vhi_i))); // R5
endmodule

// File: rtl/cursor_hit.sv
module cursor_hit
  import ext_cursor_pkg::*;
#(
  parameter int unsigned BOX_W = 12,
  parameter int unsigned BOX_H = 22
) (
  input  cursor_pos_t pos_i,
  input  pos_t        px_i,
  input  pos_t        py_i,
  output logic        hit_o
);
  localparam int unsigned EXT_W = POS_W + 1;

  logic [EXT_W-1:0] x_end, y_end;
  logic             in_x, in_y;

  assign x_end = {1'b0, pos_i.x} + EXT_W'(BOX_W);
  assign y_end = {1'b0, pos_i.y} + EXT_W'(BOX_H);
  assign in_x  = (px_i >= pos_i.x) && ({1'b0, px_i} < x_end);
  assign in_y  = (py_i >= pos_i.y) && ({1'b0, py_i} < y_end);
  assign hit_o = in_x && in_y;

  always_comb begin
    if (hit_o) begin
      AST_HIT_X: assert ((px_i - pos_i.x) < POS_W'(BOX_W)); // R6
      AST_HIT_Y: assert ((py_i - pos_i.y) < POS_W'(BOX_H)); // R7
    end
  end
endmodule

// File: rtl/ext_cursor_regs.sv
module ext_cursor_regs
  import ext_cursor_pkg::*;
#(
  parameter int unsigned NUM_REGS = 256,
  parameter int unsigned HLO_IDX  = 8'h50,
  parameter int unsigned HHI_IDX  = 8'h51,
  parameter int unsigned VLO_IDX  = 8'h52,
  parameter int unsigned VHI_IDX  = 8'h53,
  parameter int unsigned BOX_W    = 12,
  parameter int unsigned BOX_H    = 22
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [4:0]  reg_addr_i,
  input  logic        wr_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic [15:0] px_i,
  input  logic [15:0] py_i,
  output logic [15:0] cursor_x_o,
  output logic [15:0] cursor_y_o,
  output logic        in_cursor_o
);
  byte_t       hlo, hhi, vlo;
  logic        commit;
  cursor_pos_t pos;

  ext_reg_file #(
    .NUM_REGS(NUM_REGS),
    .HLO_IDX (HLO_IDX),
    .HHI_IDX (HHI_IDX),
    .VLO_IDX (VLO_IDX),
    .VHI_IDX (VHI_IDX)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .reg_addr_i(reg_addr_i),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .hlo_o     (hlo),
    .hhi_o     (hhi),
    .vlo_o     (vlo),
    .commit_o  (commit)
  );

  cursor_latch u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .commit_i(commit),
    .hlo_i   (hlo),
    .hhi_i   (hhi),
    .vlo_i   (vlo),
    .vhi_i   (wdata_i),
    .pos_o   (pos)
  );

  cursor_hit #(
    .BOX_W(BOX_W),
    .BOX_H(BOX_H)
  ) u_hit (
    .pos_i(pos),
    .px_i (px_i),
    .py_i (py_i),
    .hit_o(in_cursor_o)
  );

  assign cursor_x_o = pos.x;
  assign cursor_y_o = pos.y;

  AST_X_FROM_REGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> (cursor_x_o == {$past(hhi), $past(hlo)})); // R5
endmodule

// File: tb/tb_ext_cursor_regs.sv
`timescale 1ns/1ps
module tb_ext_cursor_regs;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic        wr_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [15:0] px_i = '0, py_i = '0;
  logic [15:0] cursor_x_o, cursor_y_o;
  logic        in_cursor_o;

  always #2 clk_i = ~clk_i;

  ext_cursor_regs dut (.*);

  int vectors = 0;
  int errors  = 0;
  logic [7:0]  m_mem [256];
  logic [7:0]  m_idx;
  logic [15:0] m_cx, m_cy;

  function automatic logic exp_hit(logic [15:0] cx, logic [15:0] cy,
                                   logic [15:0] x, logic [15:0] y);
    return (x >= cx) && ({1'b0, x} < ({1'b0, cx} + 17'd12)) &&
           (y >= cy) && ({1'b0, y} < ({1'b0, cy} + 17'd22));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // drive at negedge, commit at posedge, update model, settle to next negedge
  task automatic wr(logic [4:0] off, logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = off; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i);
    #1;
    wr_i = 1'b0;
    if (off == 5'h0E) m_idx = d;
    else if (off == 5'h0F) begin
      if (m_idx == 8'h53) begin
        m_cx = {m_mem[8'h51], m_mem[8'h50]};
        m_cy = {d, m_mem[8'h52]};
      end
      m_mem[m_idx] = d;
    end
  endtask

  task automatic rd_chk(string req, logic [4:0] off, logic [7:0] exp);
    @(negedge clk_i);
    reg_addr_i = off;
    #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic pos_chk(string req);
    chk(req, {cursor_x_o, cursor_y_o}, {m_cx, m_cy});
  endtask

  task automatic hit_chk(string req, logic [15:0] x, logic [15:0] y);
    px_i = x; py_i = y;
    #1;
    chk(req, in_cursor_o, exp_hit(m_cx, m_cy, x, y));
  endtask

  task automatic set_pos(logic [15:0] x, logic [15:0] y);
    wr(5'h0E, 8'h50); wr(5'h0F, x[7:0]);
    wr(5'h0E, 8'h51); wr(5'h0F, x[15:8]);
    wr(5'h0E, 8'h52); wr(5'h0F, y[7:0]);
    wr(5'h0E, 8'h53); wr(5'h0F, y[15:8]);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c3b4a));
    for (int i = 0; i < 256; i++) m_mem[i] = '0;
    m_idx = '0; m_cx = '0; m_cy = '0;
    #9 rst_ni = 1'b1;

    // R1 reset state
    rd_chk("R1 index", 5'h0E, 8'h00);
    rd_chk("R1 data", 5'h0F, 8'h00);
    pos_chk("R1 pos");
    hit_chk("R1 hit origin", 16'd0, 16'd0);

    // R2 / R3 index and data
    wr(5'h0E, 8'hA5);
    rd_chk("R2 index rd", 5'h0E, 8'hA5);
    wr(5'h0F, 8'h3C);
    rd_chk("R3 data rd", 5'h0F, 8'h3C);
    wr(5'h0E, 8'hFF); wr(5'h0F, 8'h77);
    rd_chk("R3 top index", 5'h0F, 8'h77);
    wr(5'h0E, 8'h00); wr(5'h0F, 8'h11);
    rd_chk("R3 bottom index", 5'h0F, 8'h11);
    wr(5'h0E, 8'hA5);
    rd_chk("R3 index kept", 5'h0F, 8'h3C);

    // R8 unmapped offsets
    wr(5'h0D, 8'h99);
    wr(5'h00, 8'h42);
    rd_chk("R8 unmapped rd", 5'h0D, 8'h00);
    rd_chk("R8 index untouched", 5'h0E, 8'hA5);
    rd_chk("R8 data untouched", 5'h0F, 8'h3C);

    // R4 partial writes do not move, R5 commit moves
    wr(5'h0E, 8'h50); wr(5'h0F, 8'h34); pos_chk("R4 hlo");
    wr(5'h0E, 8'h51); wr(5'h0F, 8'h02); pos_chk("R4 hhi");
    wr(5'h0E, 8'h52); wr(5'h0F, 8'h78); pos_chk("R4 vlo");
    chk("R4 x held", cursor_x_o, 16'h0000);
    wr(5'h0E, 8'h53); wr(5'h0F, 8'h01);
    chk("R5 commit", {cursor_x_o, cursor_y_o}, {16'h0234, 16'h0178});

    // R6 / R7 box edges at (0x234,0x178)
    hit_chk("R6 left in", 16'h0234, 16'h0178);
    hit_chk("R6 left out", 16'h0233, 16'h0178);
    hit_chk("R6 right in", 16'h0234 + 11, 16'h0178);
    hit_chk("R6 right out", 16'h0234 + 12, 16'h0178);
    hit_chk("R7 top out", 16'h0234, 16'h0177);
    hit_chk("R7 bottom in", 16'h0234, 16'h0178 + 21);
    hit_chk("R7 bottom out", 16'h0234, 16'h0178 + 22);

    // R6 / R7 no wrap near the top of the range
    set_pos(16'hFFF8, 16'hFFF0);
    pos_chk("R5 high pos");
    hit_chk("R6 no wrap x", 16'h0002, 16'hFFF2);
    hit_chk("R7 no wrap y", 16'hFFF9, 16'h0003);
    hit_chk("R6 high in", 16'hFFFF, 16'hFFFF);

    // R5 commit coinciding with comparison: old box then new box
    set_pos(16'd100, 16'd200);
    wr(5'h0E, 8'h50); wr(5'h0F, 8'd150);
    wr(5'h0E, 8'h53);
    @(negedge clk_i);
    px_i = 16'd105; py_i = 16'd205;
    reg_addr_i = 5'h0F; wdata_i = 8'h00; wr_i = 1'b1;
    #1 chk("R5 pre-commit hit", in_cursor_o, 1'b1);
    @(posedge clk_i); #1 wr_i = 1'b0;
    m_cx = 16'd150; m_cy = 16'd200; m_mem[8'h53] = 8'h00;
    chk("R5 post-commit hit", in_cursor_o, 1'b0);
    hit_chk("R6 new box", 16'd155, 16'd205);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [4:0] off;
      logic [7:0] d;
      int r;
      r = int'($urandom_range(0, 9));
      d = 8'($urandom);
      if (r < 3) begin off = 5'h0E; d = 8'h50 + 8'($urandom_range(0, 3)); end
      else if (r < 4) off = 5'h0E;
      else if (r < 8) off = 5'h0F;
      else off = 5'($urandom);
      wr(off, d);
      pos_chk("R5 random pos");
      rd_chk("R3 random rd", 5'h0F, m_mem[m_idx]);
      hit_chk("R6 random hit", m_cx + 16'($urandom_range(0, 14)) - 16'd1,
              m_cy + 16'($urandom_range(0, 24)) - 16'd1);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule